// File: doc/BRIEF.md
# Interlaced Video Sync Field Decoder

This block sits at the timing input of a digital video encoder that accepts interlaced 4:2:2 pixel data from an external timing source. It watches active-low horizontal sync, vertical sync or a field-identity level, and an optional blanking input. From the way these edges line up, it works out when each field begins and whether that field is odd or even. It keeps a line counter that is reloaded at every field start and advanced on every horizontal sync. From that count and the external blanking input, it produces an internal active-video enable.

One of two input protocols is chosen by a three-bit mode code. With the horizontal-plus-field protocol, a change of the field level while horizontal sync is held low starts a field. With the horizontal-plus-vertical protocol, the order of the two sync falls gives the parity. A standard-select input chooses 525-line or 625-line numbering. When external blanking is not in use, the block itself suppresses the vertical blanking lines of the chosen standard. A one-cycle marker shows the clock edge at which pixel data that follows a timing transition should be captured.

Top module: `vid_field_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take these values after that edge: `line_number` = 1, `field_parity` = 0, `field_start` = 0, `active_video` = 0 and `pix_latch` = 0. The sync history is set to idle: syncs high, field low and blank high.
- R2: With `mode_sel` = 3'b011, a change of `field_in` that is sampled while `hsync_n` is low raises `field_start` for one cycle after that edge. `field_parity` then takes the new `field_in` level, where 0 means odd and 1 means even.
- R3: With `mode_sel` = 3'b011, a change of `field_in` that is sampled while `hsync_n` is high does not start a field and leaves `field_parity` unchanged.
- R4: With `mode_sel` = 3'b100, when `hsync_n` and `vsync_n` fall at the same sampled edge, an odd field starts: `field_start` = 1 and `field_parity` = 0.
- R5: With `mode_sel` = 3'b100, when `vsync_n` falls while `hsync_n` is sampled high, an even field starts: `field_start` = 1 and `field_parity` = 1.
- R6: For any `mode_sel` value other than 3'b011 and 3'b100, no field start is produced and `field_parity` holds its value.
- R7: An odd field start loads `line_number` with 1. An even field start loads it with 263 (`std_625` = 0) or 313 (`std_625` = 1). Otherwise, each falling edge of `hsync_n` adds one to the count. When the count is at or above the total of 525 or 625 lines, the next falling edge returns it to 1. A field start takes priority over the increment in the same cycle.
- R8: `active_video` is low on vertical blanking lines. These are lines 1–21 and 263–284 in 525-line numbering, and lines 1–22 and 313–335 in 625-line numbering. They are judged on the `line_number` value that appears together with `active_video`.
- R9: When `blank_en` = 1, a low level on `blank_n` forces `active_video` low after that edge. When `blank_en` = 0, `blank_n` has no effect on `active_video`.
- R10: `pix_latch` is high for the one cycle after an edge at which any of `hsync_n`, `vsync_n`, `field_in` or `blank_n` was sampled different from its value at the previous edge. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Timing protocol code: 3'b011 is horizontal plus field, 3'b100 is horizontal plus vertical |
| std_625 | input | 1 | 1 selects 625-line numbering, 0 selects 525-line numbering |
| blank_en | input | 1 | 1 makes the external blanking input take effect |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| field_in | input | 1 | Field identity level (0 odd, 1 even) |
| blank_n | input | 1 | External blanking, active low |
| field_parity | output | 1 | Current field, 0 odd and 1 even |
| field_start | output | 1 | One-cycle pulse at the start of a field |
| line_number | output | LINE_W (10) | Current line number, counted from 1 |
| active_video | output | 1 | High on display lines that are not blanked |
| pix_latch | output | 1 | Marks the capture edge that follows a timing transition |

## Verification
The hardest conditions to reach are the count wrap-around at 525 and 625 and the late blanking window of each even field. Both lie hundreds of lines after a field start. The bench drives whole 16-cycle lines, with the vertical or field event placed at a fixed slot inside the line. It runs each standard through a full field pair, so the count passes the even-field load, the 263/313 boundaries, the blanking edges and the wrap back to 1. A behavioural model checks every output on every cycle along the way.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // Sync vector bit positions
  localparam int SYN_H = 0;
  localparam int SYN_V = 1;
  localparam int SYN_F = 2;
  localparam int SYN_B = 3;
  localparam int NSYNC = 4;

  // Idle levels: syncs high, field low, blank high
  localparam logic [NSYNC-1:0] SYNC_IDLE = 4'b1011;

  // Protocol codes
  localparam logic [2:0] PROTO_HFLD = 3'b011;
  localparam logic [2:0] PROTO_HVS  = 3'b100;

  typedef enum logic {
    PAR_ODD  = 1'b0,
    PAR_EVEN = 1'b1
  } parity_e;
endpackage

// File: rtl/vfd_edge_detect.sv
module vfd_edge_detect #(
  parameter int                NSIG = 4,
  parameter logic [NSIG-1:0]   IDLE = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSIG-1:0] sig_now,
  output logic [NSIG-1:0] changed
);
  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_sig
      logic held;
      always_ff @(posedge clk) begin
        if (rst) held <= IDLE[i];
        else     held <= sig_now[i];
      end
      assign changed[i] = held ^ sig_now[i];
    end
  endgenerate
endmodule

// File: rtl/vfd_field_decode.sv
module vfd_field_decode
  import vfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_sel,
  input  logic       h_fall,
  input  logic       v_fall,
  input  logic       f_change,
  input  logic       h_level,
  input  logic       f_level,
  output logic       start_d,
  output logic       par_d,
  output logic       field_start,
  output logic       field_parity
);
  always_comb begin
    start_d = 1'b0;
    par_d   = field_parity;
    case (mode_sel)
      PROTO_HFLD: begin
        if (f_change && !h_level) begin
          start_d = 1'b1;
          par_d   = f_level;
        end
      end
      PROTO_HVS: begin
        if (v_fall && h_fall) begin
          start_d = 1'b1;
          par_d   = PAR_ODD;
        end else if (v_fall && h_level) begin
          start_d = 1'b1;
          par_d   = PAR_EVEN;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_start  <= 1'b0;
      field_parity <= PAR_ODD;
    end else begin
      field_start  <= start_d;
      field_parity <= par_d;
    end
  end
endmodule

// File: rtl/vfd_line_timing.sv
module vfd_line_timing #(
  parameter int LW              = 10,
  parameter int LINES_525       = 525,
  parameter int LINES_625       = 625,
  parameter int EVEN_START_525  = 263,
  parameter int EVEN_START_625  = 313,
  parameter int VB_ODD_END_525  = 21,
  parameter int VB_EVEN_END_525 = 284,
  parameter int VB_ODD_END_625  = 22,
  parameter int VB_EVEN_END_625 = 335
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std_625,
  input  logic          start_d,
  input  logic          par_d,
  input  logic          h_fall,
  input  logic          ext_blank,
  output logic [LW-1:0] line_number,
  output logic          active_video
);
  localparam logic [LW-1:0] L_ONE   = LW'(1);
  localparam logic [LW-1:0] L_TOT5  = LW'(LINES_525);
  localparam logic [LW-1:0] L_TOT6  = LW'(LINES_625);
  localparam logic [LW-1:0] L_EV5   = LW'(EVEN_START_525);
  localparam logic [LW-1:0] L_EV6   = LW'(EVEN_START_625);
  localparam logic [LW-1:0] L_OE5   = LW'(VB_ODD_END_525);
  localparam logic [LW-1:0] L_EE5   = LW'(VB_EVEN_END_525);
  localparam logic [LW-1:0] L_OE6   = LW'(VB_ODD_END_625);
  localparam logic [LW-1:0] L_EE6   = LW'(VB_EVEN_END_625);

  logic [LW-1:0] total;
  logic [LW-1:0] even_first;
  logic [LW-1:0] odd_blank_end;
  logic [LW-1:0] even_blank_end;
  logic [LW-1:0] line_next;
  logic          vblank_next;

  always_comb begin
    total          = std_625 ? L_TOT6 : L_TOT5;
    even_first     = std_625 ? L_EV6  : L_EV5;
    odd_blank_end  = std_625 ? L_OE6  : L_OE5;
    even_blank_end = std_625 ? L_EE6  : L_EE5;
  end

  always_comb begin
    line_next = line_number;
    if (start_d)     line_next = par_d ? even_first : L_ONE;
    else if (h_fall) line_next = (line_number >= total) ? L_ONE : line_number + L_ONE;
  end

  always_comb begin
    vblank_next = ((line_next >= L_ONE) && (line_next <= odd_blank_end)) ||
                  ((line_next >= even_first) && (line_next <= even_blank_end));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_number  <= L_ONE;
      active_video <= 1'b0;
    end else begin
      line_number  <= line_next;
      active_video <= !vblank_next && !ext_blank;
    end
  end
endmodule

// File: rtl/vid_field_decoder.sv
module vid_field_decoder
  import vfd_pkg::*;
#(
  parameter int LINES_525       = 525,
  parameter int LINES_625       = 625,
  parameter int EVEN_START_525  = 263,
  parameter int EVEN_START_625  = 313,
  parameter int VB_ODD_END_525  = 21,
  parameter int VB_EVEN_END_525 = 284,
  parameter int VB_ODD_END_625  = 22,
  parameter int VB_EVEN_END_625 = 335,
  parameter int LINE_W = $clog2((LINES_625 > LINES_525 ? LINES_625 : LINES_525) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              std_625,
  input  logic              blank_en,
  input  logic              hsync_n,
  input  logic              vsync_n,
  input  logic              field_in,
  input  logic              blank_n,
  output logic              field_parity,
  output logic              field_start,
  output logic [LINE_W-1:0] line_number,
  output logic              active_video,
  output logic              pix_latch
);
  logic [NSYNC-1:0] sync_now;
  logic [NSYNC-1:0] sync_chg;
  logic             h_fall;
  logic             v_fall;
  logic             start_d;
  logic             par_d;

  assign sync_now[SYN_H] = hsync_n;
  assign sync_now[SYN_V] = vsync_n;
  assign sync_now[SYN_F] = field_in;
  assign sync_now[SYN_B] = blank_n;

  vfd_edge_detect #(
    .NSIG (NSYNC),
    .IDLE (SYNC_IDLE)
  ) u_edge (
    .clk     (clk),
    .rst     (rst),
    .sig_now (sync_now),
    .changed (sync_chg)
  );

  assign h_fall = sync_chg[SYN_H] & ~hsync_n;
  assign v_fall = sync_chg[SYN_V] & ~vsync_n;

  vfd_field_decode u_field (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .h_fall       (h_fall),
    .v_fall       (v_fall),
    .f_change     (sync_chg[SYN_F]),
    .h_level      (hsync_n),
    .f_level      (field_in),
    .start_d      (start_d),
    .par_d        (par_d),
    .field_start  (field_start),
    .field_parity (field_parity)
  );

  vfd_line_timing #(
    .LW              (LINE_W),
    .LINES_525       (LINES_525),
    .LINES_625       (LINES_625),
    .EVEN_START_525  (EVEN_START_525),
    .EVEN_START_625  (EVEN_START_625),
    .VB_ODD_END_525  (VB_ODD_END_525),
    .VB_EVEN_END_525 (VB_EVEN_END_525),
    .VB_ODD_END_625  (VB_ODD_END_625),
    .VB_EVEN_END_625 (VB_EVEN_END_625)
  ) u_line (
    .clk          (clk),
    .rst          (rst),
    .std_625      (std_625),
    .start_d      (start_d),
    .par_d        (par_d),
    .h_fall       (h_fall),
    .ext_blank    (blank_en & ~blank_n),
    .line_number  (line_number),
    .active_video (active_video)
  );

  // Capture marker: any timing input differed from its held copy
  always_ff @(posedge clk) begin
    if (rst) pix_latch <= 1'b0;
    else     pix_latch <= |sync_chg;
  end
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int LW        = 10,
  parameter int EVEN_525  = 263,
  parameter int EVEN_625  = 313,
  parameter int TOTAL_625 = 625
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode_sel,
  input logic          std_625,
  input logic          blank_en,
  input logic          blank_n,
  input logic          field_parity,
  input logic          field_start,
  input logic [LW-1:0] line_number,
  input logic          active_video,
  input logic          pix_latch
);
  AST_ODD_LINE_ONE: assert property (@(posedge clk) disable iff (rst)
    (field_start && !field_parity) |-> (line_number == LW'(1))); // R7

  AST_EVEN_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (field_start && field_parity) |->
      (line_number == ($past(std_625) ? LW'(EVEN_625) : LW'(EVEN_525)))); // R7

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (line_number >= LW'(1)) && (line_number <= LW'(TOTAL_625))); // R7

  AST_ODD_BLANK: assert property (@(posedge clk) disable iff (rst)
    ((line_number >= LW'(1)) && (line_number <= LW'(21))) |-> !active_video); // R8

  AST_EVEN_BLANK_525: assert property (@(posedge clk) disable iff (rst)
    ($past(!std_625) && (line_number >= LW'(263)) && (line_number <= LW'(284)))
      |-> !active_video); // R8

  AST_EXT_BLANK: assert property (@(posedge clk) disable iff (rst)
    $past(blank_en && !blank_n) |-> !active_video); // R9

  AST_START_MARKS_PIX: assert property (@(posedge clk) disable iff (rst)
    field_start |-> pix_latch); // R10

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    !($past(mode_sel) == 3'b011 || $past(mode_sel) == 3'b100)
      |-> (!field_start && $stable(field_parity))); // R6
endmodule

bind vid_field_decoder vfd_checker #(
  .LW        (LINE_W),
  .EVEN_525  (EVEN_START_525),
  .EVEN_625  (EVEN_START_625),
  .TOTAL_625 (LINES_625)
) u_chk (.*);

// File: tb/sim_vid_field_decoder.sv
module sim_vid_field_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'b100;
  logic       std_625 = 1'b0;
  logic       blank_en = 1'b0;
  logic       hsync_n = 1'b1;
  logic       vsync_n = 1'b1;
  logic       field_in = 1'b0;
  logic       blank_n = 1'b1;
  logic       field_parity;
  logic       field_start;
  logic [9:0] line_number;
  logic       active_video;
  logic       pix_latch;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  int m_h = 1, m_v = 1, m_f = 0, m_b = 1;
  int e_line = 1, e_par = 0, e_start = 0, e_act = 0, e_pix = 0;

  always #5 clk = ~clk;

  vid_field_decoder u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .std_625(std_625),
    .blank_en(blank_en), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .field_in(field_in), .blank_n(blank_n), .field_parity(field_parity),
    .field_start(field_start), .line_number(line_number),
    .active_video(active_video), .pix_latch(pix_latch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vblank(input int ln, input int s625);
    if (s625 != 0) return ((ln >= 1 && ln <= 22) || (ln >= 313 && ln <= 335)) ? 1 : 0;
    return ((ln >= 1 && ln <= 21) || (ln >= 263 && ln <= 284)) ? 1 : 0;
  endfunction

  // Model update from the inputs present at the coming edge, then compare
  task automatic tick();
    int hf, vf, ft, total;
    if (rst) begin
      e_line = 1; e_par = 0; e_start = 0; e_act = 0; e_pix = 0;
      m_h = 1; m_v = 1; m_f = 0; m_b = 1;
    end else begin
      hf = (m_h == 1 && hsync_n == 0) ? 1 : 0;
      vf = (m_v == 1 && vsync_n == 0) ? 1 : 0;
      ft = (m_f != int'(field_in)) ? 1 : 0;
      total = std_625 ? 625 : 525;
      e_start = 0;
      if (mode_sel == 3'b011 && ft == 1 && hsync_n == 0) begin
        e_start = 1; e_par = int'(field_in);
      end else if (mode_sel == 3'b100 && vf == 1 && hf == 1) begin
        e_start = 1; e_par = 0;
      end else if (mode_sel == 3'b100 && vf == 1 && hsync_n == 1) begin
        e_start = 1; e_par = 1;
      end
      if (e_start == 1) e_line = (e_par == 1) ? (std_625 ? 313 : 263) : 1;
      else if (hf == 1) e_line = (e_line >= total) ? 1 : e_line + 1;
      e_act = (vblank(e_line, int'(std_625)) == 0 && !(blank_en && !blank_n)) ? 1 : 0;
      e_pix = (m_h != int'(hsync_n) || m_v != int'(vsync_n) ||
               m_f != int'(field_in) || m_b != int'(blank_n)) ? 1 : 0;
      m_h = int'(hsync_n); m_v = int'(vsync_n); m_f = int'(field_in); m_b = int'(blank_n);
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(field_start) == e_start, "R2 R4 R5 field_start", int'(field_start), e_start);
    chk(int'(field_parity) == e_par, "R2 R3 field_parity", int'(field_parity), e_par);
    chk(int'(line_number) == e_line, "R7 line_number", int'(line_number), e_line);
    chk(int'(active_video) == e_act, "R8 R9 active_video", int'(active_video), e_act);
    chk(int'(pix_latch) == e_pix, "R10 pix_latch", int'(pix_latch), e_pix);
  endtask

  // One 16-cycle line; ev: 0 none, 1 vsync with hsync fall, 2 vsync fall mid-line,
  // 3 field toggle with hsync low, 4 field toggle with hsync high
  task automatic do_line(input int ev, input int es, input int ep, input string tag);
    for (int t = 0; t < 16; t++) begin
      hsync_n = (t < 4) ? 1'b0 : 1'b1;
      if (t == 0 && ev == 1) vsync_n = 1'b0;
      if (t == 8 && ev == 2) vsync_n = 1'b0;
      if (t == 1 && ev == 3) field_in = ~field_in;
      if (t == 8 && ev == 4) field_in = ~field_in;
      if (t == 15) vsync_n = 1'b1;
      tick();
      if ((ev == 1 && t == 0) || (ev == 2 && t == 8) ||
          (ev == 3 && t == 1) || (ev == 4 && t == 8)) begin
        chk(int'(field_start) == es, {tag, " start"}, int'(field_start), es);
        chk(int'(field_parity) == ep, {tag, " parity"}, int'(field_parity), ep);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state
    chk(line_number == 10'd1, "R1 line", int'(line_number), 1);
    chk(!field_start && !field_parity && !active_video && !pix_latch,
        "R1 flags", int'({field_start, field_parity, active_video, pix_latch}), 0);
    rst = 1'b0;
    tick();

    // Horizontal plus vertical protocol, 525 lines
    mode_sel = 3'b100; std_625 = 1'b0;
    do_line(1, 1, 0, "R4");
    chk(line_number == 10'd1, "R7 odd load", int'(line_number), 1);
    repeat (20) do_line(0, 0, 0, "");
    chk(active_video == 1'b0, "R8 line21 blank", int'(active_video), 0);
    do_line(0, 0, 0, "");
    chk(active_video == 1'b1, "R8 line22 active", int'(active_video), 1);
    repeat (240) do_line(0, 0, 0, "");
    do_line(2, 1, 1, "R5");
    chk(line_number == 10'd263, "R7 even load 525", int'(line_number), 263);
    repeat (262) do_line(0, 0, 0, "");
    chk(line_number == 10'd525, "R7 top 525", int'(line_number), 525);
    do_line(0, 0, 0, "");
    chk(line_number == 10'd1, "R7 wrap 525", int'(line_number), 1);

    // Unsupported code: no decode
    mode_sel = 3'b000;
    do_line(1, 0, 1, "R6");
    do_line(3, 0, 1, "R6");

    // Horizontal plus field protocol, 625 lines (field_in now 1)
    mode_sel = 3'b011; std_625 = 1'b1;
    do_line(3, 1, 0, "R2");
    chk(line_number == 10'd1, "R7 odd load 625", int'(line_number), 1);
    repeat (21) do_line(0, 0, 0, "");
    chk(active_video == 1'b0, "R8 line22 blank 625", int'(active_video), 0);
    do_line(4, 0, 0, "R3");
    chk(active_video == 1'b1, "R8 line23 active 625", int'(active_video), 1);
    do_line(4, 0, 0, "R3");
    do_line(3, 1, 1, "R2");
    chk(line_number == 10'd313, "R7 even load 625", int'(line_number), 313);
    repeat (22) do_line(0, 0, 1, "");
    chk(active_video == 1'b0, "R8 line335 blank", int'(active_video), 0);
    do_line(0, 0, 1, "");
    chk(active_video == 1'b1, "R8 line336 active", int'(active_video), 1);
    repeat (17) do_line(0, 0, 1, "");

    // External blanking on line 353
    blank_en = 1'b1; blank_n = 1'b0;
    tick();
    chk(active_video == 1'b0, "R9 forced blank", int'(active_video), 0);
    chk(pix_latch == 1'b1, "R10 blank edge marker", int'(pix_latch), 1);
    tick();
    chk(pix_latch == 1'b0, "R10 marker one cycle", int'(pix_latch), 0);
    blank_en = 1'b0;
    tick();
    chk(active_video == 1'b1, "R9 blank ignored", int'(active_video), 1);
    blank_n = 1'b1;
    tick();
    chk(line_number == 10'd353, "R7 line held", int'(line_number), 353);

    repeat (272) do_line(0, 0, 1, "");
    chk(line_number == 10'd625, "R7 top 625", int'(line_number), 625);
    do_line(0, 0, 1, "");
    chk(line_number == 10'd1, "R7 wrap 625", int'(line_number), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule